// File: doc/BRIEF.md
# Division-free fraction reducer

This unit takes two signed integers `a` and `b` and returns their greatest common divisor together with the reduced form of the fraction a/b. It never divides. Every iteration looks only at the two lowest bits of each operand. From those bits it picks one of five moves: halve both operands, swap and halve, halve `b`, or a plus or minus combination followed by a halving. Alongside the operands it keeps four two's-complement cofactors. When `b` reaches zero, the negated second cofactor over the first one is the reduced fraction.

A request is handed in with a one-cycle `start` pulse while the unit is idle, with both operands on the parallel inputs. The unit raises `busy`, runs one iteration per clock, and then presents the divisor, the numerator and the denominator together with a one-cycle `done` pulse. Common factors of two are counted while both operands are even and are restored onto the divisor at the end. The sign of each result is left as the iteration produces it, so only magnitudes and ratios are defined.

Top module: `gcd_frac_reducer`

## Requirements
- R1: After reset, `busy`, `done` and `den_zero` are low, and `gcd_out`, `num_out` and `den_out` are zero.
- R2: A `start` seen at a clock edge while `busy` is low loads `a_in` and `b_in`. `busy` is high from the next cycle until the cycle in which `done` is high.
- R3: `start` and the operand inputs are ignored while `busy` is high. The results that follow belong to the operands that were accepted.
- R4: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle.
- R5: The magnitude of `gcd_out` equals the greatest common divisor of |a| and |b|, with all common factors of two included. When b = 0 this is |a|.
- R6: For b ≠ 0, `num_out` × b equals `den_out` × a, `den_out` is nonzero and `den_zero` is low.
- R7: For b ≠ 0, the magnitudes of `num_out` and `den_out` share no common factor greater than 1.
- R8: When b = 0 at start, `done` comes exactly two clock edges after the accepting edge. In that case `gcd_out` equals a exactly, `den_out` is 0, `num_out` is -1 and `den_zero` is high.
- R9: `gcd_out`, `num_out`, `den_out` and `den_zero` change only in a cycle where `done` is high, and hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only while idle |
| a_in | input | W | Signed operand a (the numerator) |
| b_in | input | W | Signed operand b (the denominator) |
| busy | output | 1 | High while iterating |
| done | output | 1 | One-cycle completion pulse |
| gcd_out | output | W+1 | Signed greatest common divisor |
| num_out | output | W+2 | Signed numerator of the reduced fraction |
| den_out | output | W+2 | Signed denominator of the reduced fraction |
| den_zero | output | 1 | High when the denominator is zero |

## Verification
`busy` is due one edge after the accepting edge. The general case takes a data-dependent number of iterations, so the bench polls for `done` on falling edges and then checks the results against arithmetic identities computed from the operands: a Euclid divisor, a cross-multiplied ratio and a coprimality test. It does not replay the iteration. The b = 0 case has a fixed latency: `done` is due on the second falling edge after the start edge, and the bench counts those edges exactly. The one-cycle pulse is checked on the falling edge after `done`, and the held outputs are compared while the following request is still busy.

// File: rtl/gcd_frac_pkg.sv
package gcd_frac_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    typedef enum logic [2:0] {
        MV_HALVE_BOTH = 3'd0,
        MV_SWAP       = 3'd1,
        MV_HALVE_B    = 3'd2,
        MV_PLUS       = 3'd3,
        MV_MINUS      = 3'd4,
        MV_FINISH     = 3'd5
    } move_e;

endpackage

// File: rtl/gcd_move_decode.sv
module gcd_move_decode
    import gcd_frac_pkg::*;
(
    input  logic [1:0] a_lo,
    input  logic [1:0] b_lo,
    input  logic       b_zero,
    output move_e      move
);
    always_comb begin
        if (b_zero) begin
            move = MV_FINISH;
        end else begin
            unique case ({a_lo[0], b_lo[0]})
                2'b00: move = MV_HALVE_BOTH;
                2'b01: move = MV_SWAP;
                2'b10: move = MV_HALVE_B;
                default: move = (a_lo[1] != b_lo[1]) ? MV_PLUS : MV_MINUS;
            endcase
        end
    end
endmodule

// File: rtl/gcd_operand_path.sv
module gcd_operand_path
    import gcd_frac_pkg::*;
#(
    parameter int OW = 17
) (
    input  move_e                 move,
    input  logic signed [OW-1:0]  a_cur,
    input  logic signed [OW-1:0]  b_cur,
    output logic signed [OW-1:0]  a_nxt,
    output logic signed [OW-1:0]  b_nxt,
    output logic                  both_even
);
    logic signed [OW:0] a_ext;
    logic signed [OW:0] b_ext;
    logic signed [OW:0] comb_d;

    assign a_ext = {a_cur[OW-1], a_cur};
    assign b_ext = {b_cur[OW-1], b_cur};

    always_comb begin
        comb_d    = (move == MV_PLUS) ? (a_ext + b_ext) : (a_ext - b_ext);
        a_nxt     = a_cur;
        b_nxt     = b_cur;
        both_even = 1'b0;
        unique case (move)
            MV_HALVE_BOTH: begin
                a_nxt     = a_cur >>> 1;
                b_nxt     = b_cur >>> 1;
                both_even = 1'b1;
            end
            MV_SWAP: begin
                a_nxt = b_cur;
                b_nxt = a_cur >>> 1;
            end
            MV_HALVE_B: begin
                b_nxt = b_cur >>> 1;
            end
            MV_PLUS, MV_MINUS: begin
                a_nxt = b_cur;
                b_nxt = OW'(comb_d >>> 1);
            end
            default: begin
                a_nxt = a_cur;
                b_nxt = b_cur;
            end
        endcase
    end
endmodule

// File: rtl/gcd_cofactor_lane.sv
module gcd_cofactor_lane
    import gcd_frac_pkg::*;
#(
    parameter int CW = 18
) (
    input  move_e                 move,
    input  logic signed [CW-1:0]  x_cur,
    input  logic signed [CW-1:0]  y_cur,
    output logic signed [CW-1:0]  x_nxt,
    output logic signed [CW-1:0]  y_nxt
);
    always_comb begin
        x_nxt = x_cur;
        y_nxt = y_cur;
        unique case (move)
            MV_SWAP: begin
                x_nxt = y_cur <<< 1;
                y_nxt = x_cur;
            end
            MV_HALVE_B: begin
                x_nxt = x_cur <<< 1;
            end
            MV_PLUS: begin
                x_nxt = y_cur <<< 1;
                y_nxt = x_cur + y_cur;
            end
            MV_MINUS: begin
                x_nxt = y_cur <<< 1;
                y_nxt = x_cur - y_cur;
            end
            default: begin
                x_nxt = x_cur;
                y_nxt = y_cur;
            end
        endcase
    end
endmodule

// File: rtl/gcd_frac_reducer.sv
module gcd_frac_reducer
    import gcd_frac_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] a_in,
    input  logic signed [W-1:0] b_in,
    output logic                busy,
    output logic                done,
    output logic signed [W:0]   gcd_out,
    output logic signed [W+1:0] num_out,
    output logic signed [W+1:0] den_out,
    output logic                den_zero
);
    localparam int OW    = W + 1;
    localparam int CW    = W + 2;
    localparam int KW    = $clog2(W + 1);
    localparam int LANES = 2;

    typedef struct packed {
        run_state_e           st;
        logic signed [OW-1:0] a;
        logic signed [OW-1:0] b;
        logic signed [CW-1:0] u;
        logic signed [CW-1:0] v;
        logic signed [CW-1:0] t;
        logic signed [CW-1:0] w;
        logic [KW-1:0]        k;
        logic signed [OW-1:0] g;
        logic signed [CW-1:0] num;
        logic signed [CW-1:0] den;
        logic                 dz;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    move_e                move;
    logic signed [OW-1:0] a_nxt, b_nxt;
    logic                 both_even;
    logic signed [CW-1:0] x_cur [LANES];
    logic signed [CW-1:0] y_cur [LANES];
    logic signed [CW-1:0] x_nxt [LANES];
    logic signed [CW-1:0] y_nxt [LANES];

    gcd_move_decode i_decode (
        .a_lo   (r_q.a[1:0]),
        .b_lo   (r_q.b[1:0]),
        .b_zero (r_q.b == '0),
        .move   (move)
    );

    gcd_operand_path #(.OW(OW)) i_operands (
        .move      (move),
        .a_cur     (r_q.a),
        .b_cur     (r_q.b),
        .a_nxt     (a_nxt),
        .b_nxt     (b_nxt),
        .both_even (both_even)
    );

    // lane 0 carries the (u, t) pair, lane 1 the (v, w) pair
    assign x_cur[0] = r_q.u;
    assign y_cur[0] = r_q.t;
    assign x_cur[1] = r_q.v;
    assign y_cur[1] = r_q.w;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        gcd_cofactor_lane #(.CW(CW)) i_lane (
            .move  (move),
            .x_cur (x_cur[gi]),
            .y_cur (y_cur[gi]),
            .x_nxt (x_nxt[gi]),
            .y_nxt (y_nxt[gi])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st = ST_RUN;
                    r_d.a  = OW'(a_in);
                    r_d.b  = OW'(b_in);
                    r_d.u  = CW'(1);
                    r_d.v  = '0;
                    r_d.t  = '0;
                    r_d.w  = CW'(1);
                    r_d.k  = '0;
                end
            end
            ST_RUN: begin
                if (move == MV_FINISH) begin
                    r_d.st   = ST_IDLE;
                    r_d.g    = r_q.a <<< r_q.k;
                    r_d.num  = -r_q.w;
                    r_d.den  = r_q.t;
                    r_d.dz   = (r_q.t == '0);
                    r_d.done = 1'b1;
                end else begin
                    r_d.a = a_nxt;
                    r_d.b = b_nxt;
                    r_d.u = x_nxt[0];
                    r_d.t = y_nxt[0];
                    r_d.v = x_nxt[1];
                    r_d.w = y_nxt[1];
                    if (both_even) begin
                        r_d.k = r_q.k + KW'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st == ST_RUN);
    assign done     = r_q.done;
    assign gcd_out  = r_q.g;
    assign num_out  = r_q.num;
    assign den_out  = r_q.den;
    assign den_zero = r_q.dz;

endmodule

// File: rtl/gcd_frac_reducer_chk.sv
module gcd_frac_reducer_chk #(
    parameter int W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic signed [W-1:0] b_in,
    input logic                busy,
    input logic                done,
    input logic signed [W:0]   gcd_out,
    input logic signed [W+1:0] num_out,
    input logic signed [W+1:0] den_out,
    input logic                den_zero
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    zero_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (b_in == '0)) |=> busy ##1 (done && den_zero && (den_out == '0)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(gcd_out) && $stable(num_out) && $stable(den_out) && $stable(den_zero)));

endmodule

bind gcd_frac_reducer gcd_frac_reducer_chk #(.W(W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .b_in     (b_in),
    .busy     (busy),
    .done     (done),
    .gcd_out  (gcd_out),
    .num_out  (num_out),
    .den_out  (den_out),
    .den_zero (den_zero)
);

// File: tb/test_gcd_frac_reducer.sv
module test_gcd_frac_reducer;
    localparam int W = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic signed [W-1:0] a_in = '0;
    logic signed [W-1:0] b_in = '0;
    logic                busy, done, den_zero;
    logic signed [W:0]   gcd_out;
    logic signed [W+1:0] num_out, den_out;

    int checks = 0;
    int errors = 0;
    longint prev_g = 0, prev_n = 0, prev_d = 0;

    always #2 clk = ~clk;

    gcd_frac_reducer #(.W(W)) i_gcd_frac_reducer (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
        .busy(busy), .done(done), .gcd_out(gcd_out), .num_out(num_out),
        .den_out(den_out), .den_zero(den_zero)
    );

    function automatic longint mag(longint x);
        return (x < 0) ? -x : x;
    endfunction

    function automatic longint euclid(longint x, longint y);
        longint p = mag(x);
        longint q = mag(y);
        while (q != 0) begin
            longint r = p % q;
            p = q;
            q = r;
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one request; intrude drives other operands with start while busy
    task automatic run(input longint a, input longint b, input bit intrude);
        int cyc = 0;
        longint g, n, d;
        @(negedge clk);
        a_in  = W'(a);
        b_in  = W'(b);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
        chk(longint'(gcd_out) == prev_g && longint'(num_out) == prev_n &&
            longint'(den_out) == prev_d, "R9", "held gcd", longint'(gcd_out), prev_g);
        if (intrude) begin
            start = 1'b1;
            a_in  = 16'sd1234;
            b_in  = 16'sd0;
        end
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (cyc >= 3) start = 1'b0;
        end
        start = 1'b0;
        chk(done == 1'b1, "R4", "watchdog", cyc, -1);
        chk(busy == 1'b0, "R4", "busy with done", longint'(busy), 0);
        g = longint'(gcd_out);
        n = longint'(num_out);
        d = longint'(den_out);
        if (b == 0) begin
            chk(cyc == 1, "R8", "zero-den latency", cyc, 1);
            chk(g == a, "R8", "gcd equals a", g, a);
            chk(d == 0 && n == -1 && den_zero, "R8", "zero-den fraction", d, 0);
        end else begin
            chk(mag(g) == euclid(a, b), "R5", "gcd magnitude", mag(g), euclid(a, b));
            chk(n * b == d * a, "R6", "ratio", n * b, d * a);
            chk(d != 0 && !den_zero, "R6", "den nonzero", d, 1);
            chk(euclid(n, d) == 1, "R7", "coprime", euclid(n, d), 1);
        end
        if (intrude) begin
            chk(mag(g) == euclid(a, b), "R3", "start ignored while busy", mag(g), euclid(a, b));
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R4", "single pulse", longint'(done), 0);
        prev_g = g;
        prev_n = n;
        prev_d = d;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        chk(!busy && !done && !den_zero, "R1", "reset flags", longint'(busy), 0);
        chk(gcd_out == 0 && num_out == 0 && den_out == 0, "R1", "reset data",
            longint'(gcd_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after reset", longint'(busy), 0);

        run(4, 2, 0);
        run(12, 18, 0);
        run(0, 5, 0);
        run(7, 0, 0);
        run(-6, 0, 0);
        run(0, 0, 0);
        run(-6, 4, 0);
        run(1, 1, 0);
        run(1, -1, 0);
        run(-32768, -32768, 0);
        run(32767, 1, 0);
        run(48, -36, 0);
        run(-32768, 24576, 0);
        run(1000, 3, 1);
        run(30030, -6006, 1);

        for (int i = 0; i < 300; i++) begin
            longint a, b;
            int sel = $urandom_range(0, 2);
            if (sel == 0) begin
                a = longint'($signed(16'($urandom)));
                b = longint'($signed(16'($urandom)));
            end else if (sel == 1) begin
                int s = $urandom_range(0, 7);
                a = longint'($signed(8'($urandom))) <<< s;
                b = longint'($signed(8'($urandom))) <<< s;
            end else begin
                a = longint'($urandom_range(0, 40)) - 20;
                b = longint'($urandom_range(0, 40)) - 20;
            end
            run(a, b, (i % 25) == 0 && b != 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule